// File: doc/BRIEF.md
# Flash Completion Polling Engine

This block sits on the host side of a parallel flash device. After a program or erase command has been sent elsewhere, the engine is started with the address being programmed (for an erase, an address inside a sector being erased) and the byte it expects the array to hold at the end. For an erase that byte is 0xFF. The engine then reads that address over and over through a simple request/acknowledge read port. It looks at the most significant data bit, which shows the complement of the expected value until the operation has finished, and at bit 5, which the device raises when its internal operation has failed.

The decision order matters. A status bit that already shows the true value wins. A raised error bit alone does not prove failure, because the status bit can flip in the same read, so a single confirming read is issued first. Once the status bit has shown the true value, the lower bits of that same read cannot be trusted. The engine therefore makes one more read and returns that byte as the verified data. A poll limit, set by a parameter, stops a hung operation and raises its own timeout flag.

Top module: `flash_poll_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, busy_o, done_o, pass_o, fail_o, timeout_o and rd_req_o are 0 and vdata_o is 0x00.
- R2: A start_i sampled high while idle is accepted. From the next cycle busy_o and rd_req_o are 1 and rd_addr_o equals the start address.
- R3: If bit 7 of a polled byte equals bit 7 of the expected byte, the engine makes exactly one more read. It then finishes with pass_o set and vdata_o equal to that extra byte. This holds whatever the value of bit 5.
- R4: If bit 7 of a polled byte differs from the expected bit 7 and bit 5 is 0, the engine reads the same address again, unless the poll limit has been reached.
- R5: If bit 7 differs and bit 5 is 1, the engine makes one confirming read. If bit 7 of that read matches, the engine goes on as in R3. If it does not match, the engine finishes with fail_o set and vdata_o equal to the confirming byte.
- R6: Polling reads are counted, not counting confirming or verify reads. When the MAX_POLLS-th polling read mismatches with bit 5 at 0, the engine finishes with timeout_o set and vdata_o equal to that byte. If bit 5 is 1 on that read, the confirming read of R5 is made instead.
- R7: done_o is high for exactly one cycle, and busy_o falls in that same cycle. At most one of pass_o, fail_o and timeout_o is set. Those flags and vdata_o hold until the next accepted start, which clears them.
- R8: rd_req_o stays high until a cycle with rd_ack_i high. rd_addr_o does not change while busy_o is high. Every read of a job uses the start address.
- R9: start_i while busy_o is high is ignored. Neither the read address nor the result of the running job changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start a polling job |
| start_addr_i | input | ADDR_W | Address to poll |
| start_data_i | input | 8 | Expected final byte (0xFF for erase) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read response valid, completes the request |
| rd_data_i | input | 8 | Read response byte |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Job finished successfully |
| fail_o | output | 1 | Device reported failure |
| timeout_o | output | 1 | Poll limit reached |
| vdata_o | output | 8 | Verified byte on pass, last byte read otherwise |

## Verification
Two events can land on a single response byte: the status bit turning true and the error bit going high. The same holds for the error bit and the last allowed poll. Directed scripts return 0xA0 for an erase, and return the error bit on exactly the MAX_POLLS-th poll. The bench checks that the match wins with a verify read, and that the confirming read outranks the timeout. It judges each job by its outcome flag, the number of reads issued and vdata_o, all against a bench model of the decision order. Random scripts mix these bits freely under random acknowledge latency.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    localparam int unsigned STATUS_BIT = 7;
    localparam int unsigned ERROR_BIT  = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_POLL,
        ST_RECHECK,
        ST_VERIFY
    } fpe_state_e;

    typedef enum logic [1:0] {
        VD_MATCH,
        VD_RETRY,
        VD_SUSPECT
    } fpe_verdict_e;

    typedef enum logic [1:0] {
        RS_NONE,
        RS_PASS,
        RS_FAIL,
        RS_TIMEOUT
    } fpe_outcome_e;

    typedef struct packed {
        logic         valid;
        fpe_outcome_e outcome;
        logic [7:0]   data;
    } fpe_finish_t;

    // Match on the status bit outranks the error bit.
    function automatic fpe_verdict_e poll_verdict(logic [7:0] rd, logic [7:0] expv);
        logic [7:0] diff;
        diff = rd ^ expv;
        if (!diff[STATUS_BIT])
            return VD_MATCH;
        else if (rd[ERROR_BIT])
            return VD_SUSPECT;
        else
            return VD_RETRY;
    endfunction

endpackage

// File: rtl/fpe_limit.sv
module fpe_limit #(
    parameter int unsigned MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int unsigned CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            cnt_q <= '0;
        else if (step_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == CW'(MAX_POLLS - 1));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAX_POLLS));

endmodule

// File: rtl/fpe_ctrl.sv
module fpe_ctrl
    import fpe_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [7:0]        start_data_i,
    input  logic              rd_ack_i,
    input  logic [7:0]        rd_data_i,
    input  logic              last_poll_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              busy_o,
    output logic              accept_o,
    output logic              poll_step_o,
    output fpe_finish_t       fin_o
);
    fpe_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        exp_q;
    logic              xfer;
    fpe_verdict_e      verdict;

    assign rd_req_o  = (state_q != ST_IDLE);
    assign busy_o    = (state_q != ST_IDLE);
    assign rd_addr_o = addr_q;
    assign accept_o  = (state_q == ST_IDLE) && start_i;
    assign xfer      = rd_req_o && rd_ack_i;
    assign verdict   = poll_verdict(rd_data_i, exp_q);

    always_comb begin
        state_d     = state_q;
        poll_step_o = 1'b0;
        fin_o       = '{valid: 1'b0, outcome: RS_NONE, data: rd_data_i};
        unique case (state_q)
            ST_IDLE:
                if (start_i) state_d = ST_POLL;
            ST_POLL:
                if (xfer) begin
                    poll_step_o = 1'b1;
                    unique case (verdict)
                        VD_MATCH:   state_d = ST_VERIFY;
                        VD_SUSPECT: state_d = ST_RECHECK;
                        default:
                            if (last_poll_i) begin
                                state_d       = ST_IDLE;
                                fin_o.valid   = 1'b1;
                                fin_o.outcome = RS_TIMEOUT;
                            end
                    endcase
                end
            ST_RECHECK:
                if (xfer) begin
                    if (verdict == VD_MATCH) begin
                        state_d = ST_VERIFY;
                    end else begin
                        state_d       = ST_IDLE;
                        fin_o.valid   = 1'b1;
                        fin_o.outcome = RS_FAIL;
                    end
                end
            default:
                if (xfer) begin
                    state_d       = ST_IDLE;
                    fin_o.valid   = 1'b1;
                    fin_o.outcome = RS_PASS;
                end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            exp_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                addr_q <= start_addr_i;
                exp_q  <= start_data_i;
            end
        end
    end

    // R2
    start_req_chk: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> rd_req_o);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

endmodule

// File: rtl/fpe_result.sv
module fpe_result
    import fpe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear_i,
    input  fpe_finish_t fin_i,
    output logic        done_o,
    output logic        pass_o,
    output logic        fail_o,
    output logic        timeout_o,
    output logic [7:0]  vdata_o
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            done_o    <= 1'b0;
            pass_o    <= 1'b0;
            fail_o    <= 1'b0;
            timeout_o <= 1'b0;
            vdata_o   <= '0;
        end else begin
            done_o <= fin_i.valid;
            if (fin_i.valid) begin
                pass_o    <= (fin_i.outcome == RS_PASS);
                fail_o    <= (fin_i.outcome == RS_FAIL);
                timeout_o <= (fin_i.outcome == RS_TIMEOUT);
                vdata_o   <= fin_i.data;
            end
        end
    end

    // R7
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({pass_o, fail_o, timeout_o}) <= 1);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
    import fpe_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned MAX_POLLS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [7:0]        start_data_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [7:0]        rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic              timeout_o,
    output logic [7:0]        vdata_o
);
    logic        accept;
    logic        poll_step;
    logic        last_poll;
    fpe_finish_t fin;

    fpe_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .start_data_i (start_data_i),
        .rd_ack_i     (rd_ack_i),
        .rd_data_i    (rd_data_i),
        .last_poll_i  (last_poll),
        .rd_req_o     (rd_req_o),
        .rd_addr_o    (rd_addr_o),
        .busy_o       (busy_o),
        .accept_o     (accept),
        .poll_step_o  (poll_step),
        .fin_o        (fin)
    );

    fpe_limit #(.MAX_POLLS(MAX_POLLS)) i_limit (
        .clk     (clk),
        .rst     (rst),
        .clear_i (accept),
        .step_i  (poll_step),
        .last_o  (last_poll)
    );

    fpe_result i_result (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (accept),
        .fin_i     (fin),
        .done_o    (done_o),
        .pass_o    (pass_o),
        .fail_o    (fail_o),
        .timeout_o (timeout_o),
        .vdata_o   (vdata_o)
    );

endmodule

// File: tb/test_flash_poll_engine.sv
`timescale 1ns/1ps
module test_flash_poll_engine;
    localparam int AW   = 20;
    localparam int MAXP = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [7:0]    start_data_i = '0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ack_i = 1'b0;
    logic [7:0]    rd_data_i = '0;
    logic          busy_o, done_o, pass_o, fail_o, timeout_o;
    logic [7:0]    vdata_o;

    int checks = 0;
    int errors = 0;

    logic [7:0]    scr [0:63];
    int            scr_len = 0;
    int            idx = 0;
    int            dly = 0;
    int            bad_addr = 0;
    logic [AW-1:0] job_addr = '0;

    always #2.5 clk = ~clk;

    flash_poll_engine #(.ADDR_W(AW), .MAX_POLLS(MAXP)) i_flash_poll_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
        .start_data_i(start_data_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
        .pass_o(pass_o), .fail_o(fail_o), .timeout_o(timeout_o), .vdata_o(vdata_o)
    );

    function automatic logic [7:0] resp(int i);
        if (i < scr_len) return scr[i];
        return 8'h3C ^ 8'(i);
    endfunction

    // outcome: 1 pass, 2 fail, 3 timeout
    task automatic model(input logic [7:0] e, output int outc, output int nrd,
                         output logic [7:0] v);
        int i = 0;
        int polls = 0;
        logic [7:0] b;
        outc = 0;
        while (outc == 0) begin
            b = resp(i); i++; polls++;
            if (b[7] == e[7]) begin
                outc = 1; v = resp(i); i++;
            end else if (b[5]) begin
                b = resp(i); i++;
                if (b[7] == e[7]) begin outc = 1; v = resp(i); i++; end
                else begin outc = 2; v = b; end
            end else if (polls == MAXP) begin
                outc = 3; v = b;
            end
        end
        nrd = i;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Bus responder with random acknowledge latency
    always @(negedge clk) begin
        if (rd_req_o && !rst) begin
            if (dly == 0) begin
                rd_ack_i  <= 1'b1;
                rd_data_i <= resp(idx);
                if (rd_addr_o != job_addr) bad_addr++;
                idx++;
                dly = int'($urandom % 3);
            end else begin
                rd_ack_i <= 1'b0;
                dly--;
            end
        end else begin
            rd_ack_i <= 1'b0;
        end
    end

    task automatic run_job(input logic [AW-1:0] a, input logic [7:0] e);
        int outc, nrd, cyc;
        logic [7:0] v;
        logic [3:0] flags;
        bit seen;
        model(e, outc, nrd, v);
        idx = 0; bad_addr = 0; job_addr = a;
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a; start_data_i = e;
        @(negedge clk);
        start_i = 1'b0;
        // R2
        chk(busy_o && rd_req_o, "R2", "busy/req after accept", {busy_o, rd_req_o}, 2'b11);
        chk(rd_addr_o == a, "R2", "read address", int'(rd_addr_o), int'(a));
        cyc = 0; seen = 0;
        while (cyc < 2000) begin
            if (done_o) begin seen = 1; break; end
            @(negedge clk);
            cyc++;
            if (done_o) begin seen = 1; break; end
            // R9: stray start while busy
            start_i = (cyc == 2) && busy_o;
            start_addr_i = a ^ 20'h1;
            start_data_i = ~e;
        end
        start_i = 1'b0;
        chk(seen, "R7", "done seen (watchdog)", seen, 1);
        chk(!busy_o, "R7", "busy low with done", busy_o, 0);
        flags = {1'b0, timeout_o, fail_o, pass_o};
        if (outc == 1) begin
            // R3
            chk(flags == 4'b0001, "R3", "pass flags", flags, 1);
            chk(vdata_o == v, "R3", "verified byte", vdata_o, v);
        end else if (outc == 2) begin
            // R5
            chk(flags == 4'b0010, "R5", "fail flags", flags, 2);
            chk(vdata_o == v, "R5", "confirm byte", vdata_o, v);
        end else begin
            // R6
            chk(flags == 4'b0100, "R6", "timeout flags", flags, 4);
            chk(vdata_o == v, "R6", "last poll byte", vdata_o, v);
        end
        // R4
        chk(idx == nrd, "R4", "read count", idx, nrd);
        // R8 / R9
        chk(bad_addr == 0, "R9", "reads at start address", bad_addr, 0);
        @(negedge clk);
        chk(!done_o, "R7", "done one cycle", done_o, 0);
        chk({1'b0, timeout_o, fail_o, pass_o} == flags && vdata_o == v,
            "R7", "result held", {timeout_o, fail_o, pass_o}, flags);
    endtask

    task automatic load(input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3, input int n);
        scr[0] = b0; scr[1] = b1; scr[2] = b2; scr[3] = b3; scr_len = n;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1
        chk({busy_o, done_o, pass_o, fail_o, timeout_o, rd_req_o} == 6'b0,
            "R1", "outputs in reset", {busy_o, done_o, pass_o, fail_o, timeout_o, rd_req_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy_o, done_o, pass_o, fail_o, timeout_o, rd_req_o} == 6'b0 && vdata_o == 8'h00,
            "R1", "outputs after reset", {busy_o, done_o, vdata_o}, 0);

        // R3: immediate match, then verify read
        load(8'h85, 8'hA5, 8'h00, 8'h00, 2); run_job(20'h01234, 8'hA5);
        // R3: erase, status true and error bit in the same byte
        load(8'h00, 8'hA0, 8'hFF, 8'h00, 3); run_job(20'h40000, 8'hFF);
        // R5: error bit, confirm matches
        load(8'h20, 8'h80, 8'h77, 8'h00, 3); run_job(20'h40010, 8'hFF);
        // R5: error bit, confirm mismatches
        load(8'h20, 8'h24, 8'h00, 8'h00, 2); run_job(20'h40020, 8'hFF);
        // R3: expected bit 7 low
        load(8'h80, 8'h00, 8'h12, 8'h00, 3); run_job(20'h00777, 8'h12);
        // R6: plain timeout
        for (int k = 0; k < MAXP; k++) scr[k] = 8'(k + 1);
        scr_len = MAXP; run_job(20'h0ABCD, 8'h80);
        // R6: error bit on the last allowed poll
        for (int k = 0; k < MAXP - 1; k++) scr[k] = 8'h00;
        scr[MAXP-1] = 8'h20; scr[MAXP] = 8'h80; scr[MAXP+1] = 8'h11;
        scr_len = MAXP + 2; run_job(20'h0ABCE, 8'h80);

        for (int t = 0; t < 60; t++) begin
            logic [7:0] e;
            e = ($urandom % 10 < 3) ? 8'hFF : 8'($urandom);
            scr_len = 12;
            for (int k = 0; k < 12; k++) begin
                int r;
                logic [7:0] b;
                r = int'($urandom % 8);
                b = 8'($urandom);
                if (r < 5) begin b[7] = ~e[7]; b[5] = 1'b0; end
                else if (r == 5) begin b[7] = ~e[7]; b[5] = 1'b1; end
                else if (r == 6) b[7] = e[7];
                scr[k] = b;
            end
            run_job(AW'($urandom), e);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule